// File: doc/BRIEF.md
# Host I/O Control Register Window

This block gives a DSP a small set of byte-wide control and status registers inside a 256-location window of its I/O address space. An access is taken only while the host's I/O strobe is high and the upper address byte equals the window's base. The low address byte then picks a register. Data moves on bits 7:0 of a 16-bit bus.

The registers control 19 general pins, spread over three ports. Port B holds pins 0-7, port C holds pins 8-15, and port D holds pins 16-18 in its bits 2:0. Each pin has three control bits: a mode bit, a direction bit and an output latch bit. The mode bit gives the pin either to the host or to the logic fabric. The host can also read back the live level of every pin.

A power byte carries a low-power request for the fabric. Two mask bytes stop chosen signals from reaching the fabric.

Top module: `rt_ctrl_regs`

## Requirements
- R1: An access is taken only when `io_strobe` is 1 and `io_addr[15:8]` equals `BASE_HI` (default 0x04). Any other cycle writes nothing and returns `io_rdata` = 0.
- R2: A write stores only `io_wdata[7:0]` and ignores `io_wdata[15:8]`. `io_rdata[15:8]` is always 0.
- R3: These offsets are implemented: 0x00-0x02, 0x04-0x06, 0x08-0x0A, 0x0C-0x0E and 0x10-0x12. Every other offset reads 0x00, and a write to it changes no register and no output.
- R4: The mode registers sit at offset 0x00 (port B), 0x01 (port C) and 0x02 (port D). Pin n uses bit n of port B, bit n-8 of port C, or bit n-16 of port D. A mode bit of 1 gives the pin to the fabric, so `pin_out` = `fab_out` and `pin_oe` = `fab_oe`. The mode registers read back as written.
- R5: A pin with mode 0 is host-driven. Its `pin_oe` is the direction bit (offsets 0x04-0x06) and its `pin_out` is the output latch bit (offsets 0x08-0x0A). Both registers read back as written. Port D bits 7:3 read 0 and ignore writes.
- R6: Offsets 0x0C, 0x0D and 0x0E return the current `pin_in` level of ports B, C and D, whatever the pin modes are. Writes to these offsets have no effect.
- R7: Bit 0 of offset 0x10 drives `fab_lowpwr`. A 1 selects the fabric's non-turbo, low-power mode. Bits 7:1 read 0.
- R8: The mask bytes are offset 0x11 (for `fab_sig_in[7:0]`) and offset 0x12 (for `fab_sig_in[15:8]`). A 1 in a mask bit forces that `fab_sig_out` bit to 0. A 0 passes `fab_sig_in` through.
- R9: Reset (`rst_n` = 0, asynchronous) clears every register. After reset every pin is a host input with `pin_oe` = 0, turbo mode is active (`fab_lowpwr` = 0) and no fabric signal is blocked.
- R10: A written value appears on the outputs and in read data from the first rising edge after the write cycle, and not before. Read data is valid combinationally in the cycle of the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_strobe | input | 1 | Host I/O strobe, high during an access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O address (upper byte = window base, lower byte = offset) |
| io_wdata | input | 16 | Host write data, low byte used |
| io_rdata | output | 16 | Host read data, upper byte zero |
| pin_in | input | 19 | Live pin levels |
| fab_out | input | 19 | Fabric output values per pin |
| fab_oe | input | 19 | Fabric output enables per pin |
| pin_out | output | 19 | Pin output value |
| pin_oe | output | 19 | Pin output driver enable |
| fab_lowpwr | output | 1 | Fabric non-turbo (low-power) request |
| fab_sig_in | input | 16 | Signals headed into the fabric |
| fab_sig_out | output | 16 | Those signals after masking |

## Verification
Read data depends only on the strobe and the current registers. Its expected value is therefore checked in the same cycle as the read strobe, a few nanoseconds before the next rising edge. A write only takes effect at the rising edge that ends its strobe cycle. So the pin, power and mask outputs are checked one cycle later, after the strobe is released. One case also checks, inside the write cycle itself, that the old value is still present. Every expectation is queued at the falling edge where its stimulus is applied, and the monitor takes the queue just before the following rising edge. No check ever lands on an edge.

// File: rtl/rt_ctrl_regs.sv
module rt_ctrl_regs #(
  parameter int NB = 8,
  parameter int NC = 8,
  parameter int ND = 3,
  parameter logic [7:0] BASE_HI = 8'h04,
  localparam int NPIN = NB + NC + ND
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            io_strobe,
  input  logic            io_write,
  input  logic [15:0]     io_addr,
  input  logic [15:0]     io_wdata,
  output logic [15:0]     io_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] fab_out,
  input  logic [NPIN-1:0] fab_oe,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            fab_lowpwr,
  input  logic [15:0]     fab_sig_in,
  output logic [15:0]     fab_sig_out
);

  localparam logic [7:0] A_MODE0 = 8'h00, A_MODE1 = 8'h01, A_MODE2 = 8'h02;
  localparam logic [7:0] A_DIR0  = 8'h04, A_DIR1  = 8'h05, A_DIR2  = 8'h06;
  localparam logic [7:0] A_OUT0  = 8'h08, A_OUT1  = 8'h09, A_OUT2  = 8'h0A;
  localparam logic [7:0] A_PIN0  = 8'h0C, A_PIN1  = 8'h0D, A_PIN2  = 8'h0E;
  localparam logic [7:0] A_PWR   = 8'h10, A_BLK0  = 8'h11, A_BLK1  = 8'h12;
  localparam int S1 = NB;
  localparam int S2 = NB + NC;

  logic            hit, wr, impl;
  logic [7:0]      off, wb, rd_byte;
  logic [NPIN-1:0] mode, dir, olat;
  logic            pwr;
  logic [15:0]     blk;
  wire             unused_hi = ^io_wdata[15:8];

  assign hit = io_strobe && (io_addr[15:8] == BASE_HI);
  assign wr  = hit && io_write;
  assign off = io_addr[7:0];
  assign wb  = io_wdata[7:0];

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int P = (i < S1) ? 0 : (i < S2) ? 1 : 2;
    localparam int B = i - ((P == 0) ? 0 : (P == 1) ? S1 : S2);
    localparam logic [7:0] AM = (P == 0) ? A_MODE0 : (P == 1) ? A_MODE1 : A_MODE2;
    localparam logic [7:0] AD = (P == 0) ? A_DIR0  : (P == 1) ? A_DIR1  : A_DIR2;
    localparam logic [7:0] AO = (P == 0) ? A_OUT0  : (P == 1) ? A_OUT1  : A_OUT2;
    logic m_q, d_q, o_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b0;
        d_q <= 1'b0;
        o_q <= 1'b0;
      end else if (wr) begin
        if (off == AM) m_q <= wb[B];
        if (off == AD) d_q <= wb[B];
        if (off == AO) o_q <= wb[B];
      end
    end
    assign mode[i] = m_q;
    assign dir[i]  = d_q;
    assign olat[i] = o_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0;
      blk <= '0;
    end else if (wr) begin
      if (off == A_PWR)  pwr       <= wb[0];
      if (off == A_BLK0) blk[7:0]  <= wb;
      if (off == A_BLK1) blk[15:8] <= wb;
    end
  end

  always_comb begin
    impl    = 1'b1;
    rd_byte = 8'h00;
    case (off)
      A_MODE0: rd_byte = 8'(mode[S1-1:0]);
      A_MODE1: rd_byte = 8'(mode[S2-1:S1]);
      A_MODE2: rd_byte = 8'(mode[NPIN-1:S2]);
      A_DIR0:  rd_byte = 8'(dir[S1-1:0]);
      A_DIR1:  rd_byte = 8'(dir[S2-1:S1]);
      A_DIR2:  rd_byte = 8'(dir[NPIN-1:S2]);
      A_OUT0:  rd_byte = 8'(olat[S1-1:0]);
      A_OUT1:  rd_byte = 8'(olat[S2-1:S1]);
      A_OUT2:  rd_byte = 8'(olat[NPIN-1:S2]);
      A_PIN0:  rd_byte = 8'(pin_in[S1-1:0]);
      A_PIN1:  rd_byte = 8'(pin_in[S2-1:S1]);
      A_PIN2:  rd_byte = 8'(pin_in[NPIN-1:S2]);
      A_PWR:   rd_byte = {7'd0, pwr};
      A_BLK0:  rd_byte = blk[7:0];
      A_BLK1:  rd_byte = blk[15:8];
      default: impl = 1'b0;
    endcase
  end

  assign io_rdata    = (hit && !io_write) ? {8'h00, rd_byte} : 16'h0000;
  assign pin_oe      = (mode & fab_oe)  | (~mode & dir);
  assign pin_out     = (mode & fab_out) | (~mode & olat);
  assign fab_lowpwr  = pwr;
  assign fab_sig_out = fab_sig_in & ~blk;

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !io_strobe |-> io_rdata == 16'h0000);

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[15:8] == 8'h00);

  assert_unimpl_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !impl) |=> ($stable(mode) && $stable(dir) && $stable(olat) && $stable(pwr) && $stable(blk)));

  assert_dir_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == A_DIR0) |=> dir[S1-1:0] == $past(io_wdata[S1-1:0]));

  assert_pwr_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && off == A_PWR) |=> fab_lowpwr == $past(io_wdata[0]));

  assert_reset_clear_R9: assert property (@(posedge clk)
    $rose(rst_n) |-> (mode == '0 && dir == '0 && olat == '0 && !pwr && blk == '0));

endmodule

// File: tb/rt_ctrl_regs_test.sv
`timescale 1ns/1ps
module rt_ctrl_regs_test;
  localparam int NPIN = 19;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, io_strobe = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0, io_rdata;
  logic [NPIN-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NPIN-1:0] fab_out = 19'h2A5C3, fab_oe = 19'h15A3C;
  logic fab_lowpwr;
  logic [15:0] fab_sig_in = 16'hBEEF, fab_sig_out;

  rt_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .io_strobe(io_strobe), .io_write(io_write),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .pin_in(pin_in), .fab_out(fab_out), .fab_oe(fab_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .fab_lowpwr(fab_lowpwr),
    .fab_sig_in(fab_sig_in), .fab_sig_out(fab_sig_out)
  );

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [NPIN-1:0] m_mode = '0, m_dir = '0, m_lat = '0;
  logic m_pwr = 1'b0;
  logic [15:0] m_blk = '0;

  task automatic push(input int k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    q.push_back(it);
  endtask

  task automatic push_pins(input string t);
    push(1, 32'((m_mode & fab_out) | (~m_mode & m_lat)), t);
    push(2, 32'((m_mode & fab_oe) | (~m_mode & m_dir)), t);
  endtask

  task automatic push_misc(input string t);
    push(3, 32'(m_pwr), t);
    push(4, 32'(fab_sig_in & ~m_blk), t);
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_strobe = 1'b1; io_write = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_strobe = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    io_strobe = 1'b1; io_write = 1'b0; io_addr = a;
    push(0, 32'(e), t);
    @(negedge clk);
    io_strobe = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = 32'(io_rdata);
          1: act = 32'(pin_out);
          2: act = 32'(pin_oe);
          3: act = 32'(fab_lowpwr);
          default: act = 32'(fab_sig_out);
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    push_pins("R9 reset pins"); push_misc("R9 reset misc");
    rd(16'h0400, 16'h0000, "R9 mode B");
    rd(16'h0410, 16'h0000, "R9 power");

    // R5 / R2 host direction and latch, upper write byte ignored
    wr(16'h0404, 16'hFFA5); m_dir[7:0] = 8'hA5; push_pins("R5 dir B");
    rd(16'h0404, 16'h00A5, "R2 readback dir B");
    wr(16'h0408, 16'h773C); m_lat[7:0] = 8'h3C; push_pins("R5 latch B");
    rd(16'h0408, 16'h003C, "R5 readback latch B");

    // R10 timing of a latch write
    wr(16'h0405, 16'h00FF); m_dir[15:8] = 8'hFF;
    @(negedge clk);
    io_strobe = 1'b1; io_write = 1'b1; io_addr = 16'h0409; io_wdata = 16'h0055;
    push_pins("R10 old value during write");
    @(negedge clk);
    io_strobe = 1'b0; io_write = 1'b0;
    m_lat[15:8] = 8'h55; push_pins("R10 new value after edge");

    // R4 fabric mode
    wr(16'h0401, 16'h00F0); m_mode[15:12] = 4'hF; push_pins("R4 port C fabric");
    rd(16'h0401, 16'h00F0, "R4 readback mode C");

    // R5 port D narrow
    wr(16'h0406, 16'h00FF); m_dir[18:16] = 3'h7; push_pins("R5 dir D");
    rd(16'h0406, 16'h0007, "R5 port D upper bits");
    wr(16'h0402, 16'h00FF); m_mode[18:16] = 3'h7; push_pins("R4 port D fabric");

    // R6 pin readback
    @(negedge clk); pin_in = 19'h51234;
    rd(16'h040C, 16'h0034, "R6 pins B");
    rd(16'h040D, 16'h0012, "R6 pins C");
    rd(16'h040E, 16'h0005, "R6 pins D");
    wr(16'h040C, 16'h00FF); push_pins("R6 write ignored pins");
    rd(16'h040C, 16'h0034, "R6 write ignored readback");

    // R3 unimplemented offsets
    wr(16'h0403, 16'h00FF); wr(16'h0420, 16'h00FF); wr(16'h04FF, 16'h00FF);
    push_pins("R3 unimpl pins"); push_misc("R3 unimpl misc");
    rd(16'h0403, 16'h0000, "R3 read 0x03");
    rd(16'h04FF, 16'h0000, "R3 read 0xFF");
    rd(16'h0404, 16'h00A5, "R3 dir B kept");

    // R1 wrong base
    wr(16'h0504, 16'h0000); push_pins("R1 other base write");
    rd(16'h0504, 16'h0000, "R1 other base read");
    rd(16'h0404, 16'h00A5, "R1 dir B kept");

    // R7 power
    wr(16'h0410, 16'h00FF); m_pwr = 1'b1; push_misc("R7 lowpwr set");
    rd(16'h0410, 16'h0001, "R7 readback");

    // R8 gating masks
    wr(16'h0411, 16'h000F); wr(16'h0412, 16'h0080); m_blk = 16'h800F;
    push_misc("R8 masked signals");
    push(4, 32'h0000_3EE0, "R8 literal");
    rd(16'h0412, 16'h0080, "R8 readback");

    // R9 second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_mode = '0; m_dir = '0; m_lat = '0; m_pwr = 1'b0; m_blk = '0;
    push_pins("R9 re-reset pins"); push_misc("R9 re-reset misc");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule